// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit works out where a single load or store goes in memory and what the base register should hold afterwards. It takes the base register value and an offset. The offset is either an immediate or a register value already passed through the shifter. An up/down input chooses whether the offset is added to or taken from the base, with the result wrapping modulo 2^32.

In pre-indexed mode the access goes to the adjusted address, and the base is rewritten only when writeback is requested. In post-indexed mode the access goes to the untouched base, and the base is always rewritten with the adjusted value. Loads and stores behave the same way.

A size input picks a whole word or one byte, and the unit drives four lane enables to match. An inhibit input blocks the base writeback, for example when the instruction's condition fails. The unit is purely combinational.

Top module: `ldst_addr_gen`

## Requirements
- R1: When `pre_index_i` is 1 (pre-indexed), `addr_o` equals the adjusted value `base_i` plus or minus `offset_i`.
- R2: When `pre_index_i` is 0 (post-indexed), `addr_o` equals `base_i` unchanged.
- R3: `new_base_o` always equals the adjusted value `base_i` plus or minus `offset_i`, in either indexing mode.
- R4: In pre-indexed mode with `wb_inhibit_i` low, `base_wb_o` equals `wb_req_i`.
- R5: In post-indexed mode with `wb_inhibit_i` low, `base_wb_o` is 1 whatever the value of `wb_req_i`.
- R6: `up_i` = 1 adds the offset and `up_i` = 0 subtracts it. Both wrap modulo 2^32, with no carry or borrow kept.
- R7: When `byte_i` is 0 (word access), `byte_en_o` is 4'b1111.
- R8: When `byte_i` is 1 (byte access), `byte_en_o` has only bit `addr_o[1:0]` set. Bit 0 is the lane at the lowest address.
- R9: When `wb_inhibit_i` is 1, `base_wb_o` is 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Base register value |
| offset_i | input | 32 | Immediate or pre-shifted register offset |
| pre_index_i | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| wb_req_i | input | 1 | Base writeback requested (used in pre-indexed mode) |
| up_i | input | 1 | 1 = add offset, 0 = subtract offset |
| byte_i | input | 1 | 1 = single-byte access, 0 = word access |
| wb_inhibit_i | input | 1 | Suppresses base writeback when 1 |
| addr_o | output | 32 | Memory access address |
| byte_en_o | output | 4 | Byte lane enables for the access |
| new_base_o | output | 32 | Updated base value |
| base_wb_o | output | 1 | Base writeback enable |

## Verification
The unit holds no state, so any fault in the adder, the mode select or the lane decoder shows at the ports in the same cycle as the stimulus. The bench compares every output once per clock against a behavioural model. It sweeps all 32 combinations of mode, writeback request, direction, size and inhibit over several base/offset pairs. These pairs include wrap in both directions and every value of the low two address bits. A wrong carry-in shows as an off-by-one `new_base_o` on subtract only. A swapped mode select shows as `addr_o` following the wrong operand.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic {
        IDX_POST = 1'b0,
        IDX_PRE  = 1'b1
    } idx_mode_e;

    typedef enum logic {
        SZ_WORD = 1'b0,
        SZ_BYTE = 1'b1
    } acc_size_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } idx_dir_e;

endpackage

// File: rtl/agu_offset_adder.sv
module agu_offset_adder
    import agu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] base_i,
    input  logic [WIDTH-1:0] offset_i,
    input  idx_dir_e         dir_i,
    output logic [WIDTH-1:0] sum_o
);

    logic [WIDTH-1:0] operand_b;
    logic             carry_in;
    logic [WIDTH:0]   full_sum;

    // Subtraction is base + ~offset + 1; a single adder serves both directions.
    always_comb begin
        operand_b = (dir_i == DIR_UP) ? offset_i : ~offset_i;
        carry_in  = (dir_i == DIR_DOWN);
        full_sum  = {1'b0, base_i} + {1'b0, operand_b} + {{WIDTH{1'b0}}, carry_in};
        sum_o     = full_sum[WIDTH-1:0];
    end

    always_comb begin
        if (offset_i == '0) begin
            AST_ZERO_OFFSET_KEEPS_BASE: assert (sum_o == base_i); // R6
        end
    end

endmodule

// File: rtl/agu_lane_decode.sv
module agu_lane_decode
    import agu_pkg::*;
#(
    parameter int LANES = 4,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [SEL_W-1:0] lane_sel_i,
    input  acc_size_e        size_i,
    output logic [LANES-1:0] lane_en_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_en_o[g] = (size_i == SZ_WORD) || (lane_sel_i == SEL_W'(g));
        end
    end

    always_comb begin
        if (size_i == SZ_WORD) begin
            AST_WORD_ALL_LANES: assert (&lane_en_o); // R7
        end else begin
            AST_BYTE_ONE_LANE: assert ($countones(lane_en_o) == 1); // R8
        end
    end

endmodule

// File: rtl/agu_wb_ctrl.sv
module agu_wb_ctrl
    import agu_pkg::*;
(
    input  idx_mode_e mode_i,
    input  logic      wb_req_i,
    input  logic      inhibit_i,
    output logic      wb_en_o
);

    logic wb_wanted;

    always_comb begin
        unique case (mode_i)
            IDX_PRE:  wb_wanted = wb_req_i;
            IDX_POST: wb_wanted = 1'b1;
            default:  wb_wanted = 1'b0;
        endcase
        wb_en_o = wb_wanted && !inhibit_i;
    end

    always_comb begin
        if (inhibit_i) begin
            AST_INHIBIT_BLOCKS_WB: assert (!wb_en_o); // R9
        end
        if (!inhibit_i && mode_i == IDX_POST) begin
            AST_POST_ALWAYS_WB: assert (wb_en_o); // R5
        end
    end

endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic              pre_index_i,
    input  logic              wb_req_i,
    input  logic              up_i,
    input  logic              byte_i,
    input  logic              wb_inhibit_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LANES-1:0]  byte_en_o,
    output logic [ADDR_W-1:0] new_base_o,
    output logic              base_wb_o
);

    idx_mode_e         mode;
    idx_dir_e          dir;
    acc_size_e         size;
    logic [ADDR_W-1:0] adjusted;

    always_comb begin
        mode = pre_index_i ? IDX_PRE : IDX_POST;
        dir  = up_i ? DIR_UP : DIR_DOWN;
        size = byte_i ? SZ_BYTE : SZ_WORD;
    end

    agu_offset_adder #(.WIDTH(ADDR_W)) u_adder (
        .base_i   (base_i),
        .offset_i (offset_i),
        .dir_i    (dir),
        .sum_o    (adjusted)
    );

    always_comb begin
        unique case (mode)
            IDX_PRE:  addr_o = adjusted;
            IDX_POST: addr_o = base_i;
            default:  addr_o = base_i;
        endcase
        new_base_o = adjusted;
    end

    agu_lane_decode #(.LANES(LANES)) u_lanes (
        .lane_sel_i (addr_o[SEL_W-1:0]),
        .size_i     (size),
        .lane_en_o  (byte_en_o)
    );

    agu_wb_ctrl u_wb (
        .mode_i    (mode),
        .wb_req_i  (wb_req_i),
        .inhibit_i (wb_inhibit_i),
        .wb_en_o   (base_wb_o)
    );

    always_comb begin
        if (mode == IDX_PRE) begin
            AST_PRE_ADDR_IS_NEW_BASE: assert (addr_o == new_base_o); // R1
        end else begin
            AST_POST_ADDR_IS_BASE: assert (addr_o == base_i); // R2
        end
    end

endmodule

// File: tb/sim_ldst_addr_gen.sv
module sim_ldst_addr_gen;

    logic        clk = 1'b0;
    logic [31:0] base_i = '0;
    logic [31:0] offset_i = '0;
    logic        pre_index_i = 1'b0;
    logic        wb_req_i = 1'b0;
    logic        up_i = 1'b0;
    logic        byte_i = 1'b0;
    logic        wb_inhibit_i = 1'b0;
    logic [31:0] addr_o;
    logic [3:0]  byte_en_o;
    logic [31:0] new_base_o;
    logic        base_wb_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  reported = 1'b0;

    always #5 clk = ~clk;

    ldst_addr_gen u0 (
        .base_i       (base_i),
        .offset_i     (offset_i),
        .pre_index_i  (pre_index_i),
        .wb_req_i     (wb_req_i),
        .up_i         (up_i),
        .byte_i       (byte_i),
        .wb_inhibit_i (wb_inhibit_i),
        .addr_o       (addr_o),
        .byte_en_o    (byte_en_o),
        .new_base_o   (new_base_o),
        .base_wb_o    (base_wb_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Behavioural model compared against every output once per clock
    task automatic compare_all();
        logic [31:0] m_sum;
        logic [31:0] m_addr;
        logic [3:0]  m_be;
        logic        m_wb;
        m_sum  = up_i ? base_i + offset_i : base_i - offset_i;
        m_addr = pre_index_i ? m_sum : base_i;
        m_be   = byte_i ? (4'b0001 << m_addr[1:0]) : 4'b1111;
        if (wb_inhibit_i)     m_wb = 1'b0;
        else if (pre_index_i) m_wb = wb_req_i;
        else                  m_wb = 1'b1;
        check(pre_index_i ? "R1" : "R2", "addr", addr_o, m_addr);
        check(up_i ? "R3" : "R3 R6", "new_base", new_base_o, m_sum);
        check(byte_i ? "R8" : "R7", "byte_en", {28'd0, byte_en_o}, {28'd0, m_be});
        check(wb_inhibit_i ? "R9" : (pre_index_i ? "R4" : "R5"), "base_wb",
              {31'd0, base_wb_o}, {31'd0, m_wb});
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] bases [8];
        logic [31:0] offs  [8];
        bases[0] = 32'h0000_1000; offs[0] = 32'h0000_0004;
        bases[1] = 32'h0000_0000; offs[1] = 32'h0000_0001;
        bases[2] = 32'hFFFF_FFFF; offs[2] = 32'h0000_0002;
        bases[3] = 32'h8000_0001; offs[3] = 32'h0000_0002;
        bases[4] = 32'h1234_5678; offs[4] = 32'h0000_0000;
        bases[5] = 32'h0000_0103; offs[5] = 32'hFFFF_FFFF;
        bases[6] = 32'hDEAD_BEEE; offs[6] = 32'h0000_0F03;
        bases[7] = 32'h7FFF_FFFE; offs[7] = 32'h8000_0003;

        // Idle inputs (all zero): post-indexed word access at 0
        @(negedge clk);
        check("R2", "idle addr", addr_o, 32'h0);
        check("R7", "idle byte_en", {28'd0, byte_en_o}, 32'hF);
        check("R5", "idle base_wb", {31'd0, base_wb_o}, 32'h1);

        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 32; c++) begin
                @(posedge clk);
                base_i       <= bases[p];
                offset_i     <= offs[p];
                pre_index_i  <= c[0];
                wb_req_i     <= c[1];
                up_i         <= c[2];
                byte_i       <= c[3];
                wb_inhibit_i <= c[4];
                @(negedge clk);
                compare_all();
            end
        end

        // Directed corner: subtract wrap below zero, pre-indexed byte at lane 3
        @(posedge clk);
        base_i <= 32'h0; offset_i <= 32'h1; pre_index_i <= 1'b1;
        wb_req_i <= 1'b0; up_i <= 1'b0; byte_i <= 1'b1; wb_inhibit_i <= 1'b0;
        @(negedge clk);
        check("R6", "wrap new_base", new_base_o, 32'hFFFF_FFFF);
        check("R8", "lane 3 enable", {28'd0, byte_en_o}, 32'h8);
        check("R4", "pre no request", {31'd0, base_wb_o}, 32'h0);

        // Post-indexed ignores wb_req_i
        @(posedge clk);
        pre_index_i <= 1'b0; wb_req_i <= 1'b0; base_i <= 32'h0000_0002;
        @(negedge clk);
        check("R5", "post wb without request", {31'd0, base_wb_o}, 32'h1);
        check("R8", "post lane from base", {28'd0, byte_en_o}, 32'h4);

        finish_run();
    end

endmodule